// File: doc/BRIEF.md
# PLL Output Clock Divider Chain

This block sits behind a 96 MHz PLL and derives two clocks from it. The system clock comes from a power-of-two postscaler, picked by a 2-bit select, followed by a fixed divide-by-three stage. This gives 32, 16, 8 or 4 MHz. A separate divide-by-two branch gives a 48 MHz clock for a USB module. The offered system rates are the same whatever input prescaler is used ahead of the PLL.

An instruction-rate strobe fires once every two system clock periods, so the instruction rate is half the system rate: 16, 8, 4 or 2 MIPS. A conflict flag warns when USB is enabled while one of the two slowest settings is selected. Those settings cannot be used with USB.

All outputs are registered in the 96 MHz domain. A new select value is taken up only where a system clock period ends, so the system clock never produces a runt pulse.

Top module: `pll_clk_divider`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all counters clear and `sys_clk`, `usb_clk`, `instr_stb` and `usb_conflict` are 0 after that edge. The select value present during reset is the one in use when reset is released.
- R2: `usb_clk` toggles on every input clock edge after reset, starting at 1. This gives half the input rate (48 MHz from 96 MHz).
- R3: The system clock period is 3·N input cycles, where N depends on `div_sel`: 00 gives N=1, 01 gives N=2, 10 gives N=4 and 11 gives N=8.
- R4: Count the cycles t = 0 … 3N−1 from the start of a system clock period, with t=0 as the first cycle after reset release or after a period end. `sys_clk` is high one cycle after each t below ⌊3N/2⌋ and low one cycle after every other t. This gives a 50% duty cycle for N≥2 and 1/3 for N=1.
- R5: `instr_stb` is a one-cycle pulse registered from t = 3N−1 of every second system clock period after reset (the 2nd, 4th, …). It is never high together with `sys_clk`.
- R6: A change of `div_sel` is adopted only at the end of the current system clock period. The period in progress finishes with its old ratio.
- R7: `usb_conflict` is 1 one cycle after `usb_en`=1 is sampled together with `div_sel` = 10 or 11, and is 0 otherwise. It has no effect on any clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | 96 MHz clock from the PLL |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 2 | Postscaler select: 00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8 |
| usb_en | input | 1 | USB module enabled |
| sys_clk | output | 1 | System clock (input ÷ 3N) |
| usb_clk | output | 1 | USB clock (input ÷ 2) |
| instr_stb | output | 1 | One-cycle strobe every two system periods |
| usb_conflict | output | 1 | Slow setting selected while USB is enabled |

## Verification
Every output is one register away from the state or inputs it depends on. `sys_clk`, `instr_stb` and `usb_clk` therefore reflect the counter position one input cycle earlier. `usb_conflict` reflects the `usb_en`/`div_sel` pair sampled at the previous rising edge. A select change becomes visible only from the first cycle of the following system clock period.

The bench steps a behavioural model of period position and period parity at each rising edge, using the same sampled inputs as the design. It compares all four outputs at every falling edge, so each expected value is due exactly one edge after its cause. Select and enable changes are made at falling edges in the middle of periods, so the deferred adoption is exercised.

// File: rtl/clkdiv_pkg.sv
// Package: clkdiv_pkg
// Shared constants, types and helper functions for the PLL output divider
// chain. Assumes the postscaler ratio is 2**select and the odd stage is fixed.
package clkdiv_pkg;
    localparam int SEL_W    = 2;                    // width of the ratio select
    localparam int ODD_DIV  = 3;                    // fixed odd divide ratio
    localparam int PRE_W    = (1 << SEL_W) - 1;     // bits to count up to 2**(2**SEL_W-1)-1
    localparam int PH_W     = $clog2(ODD_DIV);      // odd stage phase counter width
    localparam int SLOW_MIN = 2;                    // first select code unusable with USB

    typedef logic [SEL_W-1:0] sel_t;

    // Postscaler ratio for a select code.
    function automatic int ratio_of(sel_t s);
        return 1 << s;
    endfunction

    // Terminal count of the postscaler for a select code.
    function automatic logic [PRE_W-1:0] pre_last(sel_t s);
        return PRE_W'(ratio_of(s) - 1);
    endfunction
endpackage

// File: rtl/clkdiv_postscale.sv
// Module: clkdiv_postscale
// Power-of-two postscaler. Counts input cycles 0..N-1 with N = 2**sel and
// flags the last one. Assumes sel only changes when the count is at 0.
module clkdiv_postscale
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sel_t             sel,
    output logic [PRE_W-1:0] cnt,
    output logic             tick
);
    // Last cycle of the current postscaler interval.
    always_comb tick = (cnt == pre_last(sel));

    // Postscaler count, wraps on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/clkdiv_oddstage.sv
// Module: clkdiv_oddstage
// Fixed odd divider driven by the postscaler tick. Produces a registered
// system clock with its high phase first, a period-end flag, and a strobe
// every second period. Assumes sel is held for a full period.
module clkdiv_oddstage
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sel_t             sel,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre_cnt,
    output logic             wrap,
    output logic             sys_clk,
    output logic             instr_stb
);
    logic [PH_W-1:0] phase;
    logic            second;
    logic            high_now;

    // Period ends on the last postscaler cycle of the last phase.
    always_comb wrap = tick && (phase == PH_W'(ODD_DIV - 1));

    // High while the position in the period is below half its length.
    always_comb begin
        high_now = (int'(phase) * ratio_of(sel) + int'(pre_cnt))
                   < ((ODD_DIV * ratio_of(sel)) / 2);
    end

    // Phase count and period parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            second <= 1'b0;
        end else if (tick) begin
            phase  <= wrap ? '0 : phase + 1'b1;
            second <= wrap ? ~second : second;
        end
    end

    // Registered clock and strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_clk   <= 1'b0;
            instr_stb <= 1'b0;
        end else begin
            sys_clk   <= high_now;
            instr_stb <= wrap && second;
        end
    end
endmodule

// File: rtl/clkdiv_usbhalf.sv
// Module: clkdiv_usbhalf
// Half-rate USB clock toggle and the registered flag for select codes that
// cannot run with USB enabled. Assumes usb_en is synchronous to clk.
module clkdiv_usbhalf
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic usb_en,
    input  sel_t sel_req,
    output logic usb_clk,
    output logic conflict
);
    // Toggle every cycle for a divide by two.
    always_ff @(posedge clk) begin
        if (!rst_n)
            usb_clk <= 1'b0;
        else
            usb_clk <= ~usb_clk;
    end

    // Flag slow settings requested while USB is on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            conflict <= 1'b0;
        else
            conflict <= usb_en && (int'(sel_req) >= SLOW_MIN);
    end
endmodule

// File: rtl/pll_clk_divider.sv
// Module: pll_clk_divider
// Top of the divider chain behind the 96 MHz PLL. Holds the active select,
// which is taken from div_sel in reset and at each system period end.
// Assumes all inputs are synchronous to clk_in.
module pll_clk_divider
    import clkdiv_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             usb_en,
    output logic             sys_clk,
    output logic             usb_clk,
    output logic             instr_stb,
    output logic             usb_conflict
);
    sel_t             sel_act;
    logic [PRE_W-1:0] pre_cnt;
    logic             pre_tick;
    logic             period_end;

    // Active select: loaded in reset and at period boundaries only.
    always_ff @(posedge clk_in) begin
        if (!rst_n || period_end)
            sel_act <= div_sel;
    end

    clkdiv_postscale u_post (
        .clk   (clk_in),
        .rst_n (rst_n),
        .sel   (sel_act),
        .cnt   (pre_cnt),
        .tick  (pre_tick)
    );

    clkdiv_oddstage u_odd (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .sel       (sel_act),
        .tick      (pre_tick),
        .pre_cnt   (pre_cnt),
        .wrap      (period_end),
        .sys_clk   (sys_clk),
        .instr_stb (instr_stb)
    );

    clkdiv_usbhalf u_usb (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .usb_en   (usb_en),
        .sel_req  (div_sel),
        .usb_clk  (usb_clk),
        .conflict (usb_conflict)
    );
endmodule

// File: rtl/pll_clk_divider_checker.sv
// Module: pll_clk_divider_checker
// Port-level properties of the divider chain, bound into every instance.
module pll_clk_divider_checker (
    input logic       clk_in,
    input logic       rst_n,
    input logic [1:0] div_sel,
    input logic       usb_en,
    input logic       sys_clk,
    input logic       usb_clk,
    input logic       instr_stb,
    input logic       usb_conflict
);
    assert_reset_clear_R1: assert property (@(posedge clk_in)
        !rst_n |=> (!sys_clk && !usb_clk && !instr_stb && !usb_conflict));

    assert_usb_toggle_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        rst_n |=> (usb_clk != $past(usb_clk)));

    assert_strobe_single_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        instr_stb |=> !instr_stb);

    assert_strobe_low_phase_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        instr_stb |-> !sys_clk);

    assert_conflict_follow_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
        rst_n |=> (usb_conflict == ($past(usb_en) && $past(div_sel[1]))));
endmodule

bind pll_clk_divider pll_clk_divider_checker u_chk (
    .clk_in       (clk_in),
    .rst_n        (rst_n),
    .div_sel      (div_sel),
    .usb_en       (usb_en),
    .sys_clk      (sys_clk),
    .usb_clk      (usb_clk),
    .instr_stb    (instr_stb),
    .usb_conflict (usb_conflict)
);

// File: tb/test_pll_clk_divider.sv
// Bench for pll_clk_divider: behavioural model of period position and
// parity, compared with all outputs at every falling edge.
module test_pll_clk_divider;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       usb_en  = 1'b0;
    logic       sys_clk, usb_clk, instr_stb, usb_conflict;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit done    = 1'b0;

    // Model state
    int t = 0, n = 1, pcount = 0;
    logic e_sys = 0, e_usb = 0, e_stb = 0, e_cf = 0;

    always #5 clk_in = ~clk_in;

    pll_clk_divider i_pll_clk_divider (
        .clk_in       (clk_in),
        .rst_n        (rst_n),
        .div_sel      (div_sel),
        .usb_en       (usb_en),
        .sys_clk      (sys_clk),
        .usb_clk      (usb_clk),
        .instr_stb    (instr_stb),
        .usb_conflict (usb_conflict)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Reference model: outputs from the old position, then advance.
    always @(posedge clk_in) begin
        started = 1'b1;
        if (!rst_n) begin
            t = 0; pcount = 0; n = 1 << div_sel;
            e_sys = 0; e_usb = 0; e_stb = 0; e_cf = 0;
        end else begin
            e_sys = (t < (3 * n) / 2);
            e_stb = (t == 3 * n - 1) && (pcount % 2 == 1);
            e_usb = ~e_usb;
            e_cf  = usb_en && (div_sel >= 2);
            if (t == 3 * n - 1) begin
                t = 0;
                pcount++;
                n = 1 << div_sel;   // R6: new ratio only from the next period
            end else begin
                t++;
            end
        end
    end

    // Compare every cycle
    always @(negedge clk_in) begin
        if (started && !done) begin
            chk("R3 R4 R6 sys_clk", sys_clk, e_sys);
            chk("R2 usb_clk", usb_clk, e_usb);
            chk("R5 instr_stb", instr_stb, e_stb);
            chk("R7 usb_conflict", usb_conflict, e_cf);
        end
    end

    task automatic run(input int cycles);
        repeat (cycles) @(negedge clk_in);
    endtask

    initial begin
        run(3);
        // R1: explicit reset-state checks
        chk("R1 sys_clk in reset", sys_clk, 1'b0);
        chk("R1 usb_clk in reset", usb_clk, 1'b0);
        chk("R1 instr_stb in reset", instr_stb, 1'b0);
        chk("R1 usb_conflict in reset", usb_conflict, 1'b0);
        rst_n = 1'b1;
        run(61);
        div_sel = 2'b01;            // mid-period change, R6
        run(53);
        usb_en = 1'b1;              // no conflict at 01, R7
        run(20);
        div_sel = 2'b10;            // conflict expected, R7
        run(97);
        div_sel = 2'b11;
        run(131);
        usb_en = 1'b0;
        run(40);
        div_sel = 2'b00;            // leave slow ratio mid-period, R6
        run(37);
        usb_en = 1'b1;
        run(15);
        div_sel = 2'b10;
        rst_n = 1'b0;               // R1: reset mid-run adopts 10
        run(2);
        chk("R1 sys_clk after mid-run reset", sys_clk, 1'b0);
        rst_n = 1'b1;
        run(90);
        div_sel = 2'b01;
        usb_en = 1'b0;
        run(70);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk_in);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule